// File: doc/BRIEF.md
# Host Command Decoder with Status Readback

The block sits behind a host link and turns a stream of command words into a bank of configuration registers. Each word carries an opcode and a value. Most opcodes load one register: the operating mode, the detection threshold, a per-stream enable mask, or one of six chirp timing parameters. One opcode fires a trigger pulse and stores nothing. All other opcodes are dropped.

A status-request opcode freezes a snapshot of every setting in the command clock domain. The request then crosses to a separate transmit clock domain by flipping a toggle line. The transmit side detects the flip and sends the snapshot as a burst of seven words on a valid/last stream. If a second request arrives while a burst is going out, it is queued and sent afterwards.

Top module: `host_cmd_decoder`

## Requirements
- R1: While reset is held and just after release, mode, threshold, all timing fields and chirps-per-elevation read 0, the stream mask reads 3'b001, and trigger_o and stat_valid_o are low.
- R2: A word is accepted on a rising clk_i edge with cmd_valid_i high. The opcode is cmd_word_i[23:16] and the value is cmd_word_i[15:0]. The addressed register shows the new value from that edge on. With cmd_valid_i low, nothing changes.
- R3: Opcode 0x01 loads mode_o from value[1:0].
- R4: Opcode 0x02 raises trigger_o for exactly the one cycle after the accepting edge and changes no register.
- R5: Opcode 0x03 loads cfar_thr_o from value[15:0]. Opcode 0x04 loads stream_mask_o from value[2:0].
- R6: Opcodes 0x10, 0x11, 0x12, 0x13 and 0x14 load long_chirp_o, short_chirp_o, long_listen_o, guard_o and short_listen_o with the full 16-bit value. Opcode 0x15 loads chirps_per_elev_o from value[7:0].
- R7: Any opcode outside 0x01–0x04, 0x10–0x15 and 0xFF leaves every register unchanged and gives no trigger pulse.
- R8: Each 0xFF request yields exactly one burst on clk_tx_i: seven consecutive cycles with stat_valid_o high and stat_last_o high only on the seventh. At least one idle cycle follows each burst.
- R9: The burst order is as follows. Word 0 is {chirps_per_elev[7:0], 3'b000, stream_mask[2:0], mode[1:0]}. Word 1 is the threshold. Words 2 to 6 are the timing fields of opcodes 0x10 to 0x14, in opcode order.
- R10: The burst reflects the settings at the edge that accepted 0xFF. Writes accepted after that edge do not appear in it.
- R11: When idle, the first burst word appears within 5 clk_tx_i cycles after the request is accepted.
- R12: A request that arrives while a burst is being sent is not lost. Its burst follows the current one and carries that request's own snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| clk_tx_i | input | 1 | Transmit domain clock |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_word_i | input | 24 | Opcode [23:16], value [15:0] |
| mode_o | output | 2 | Operating mode |
| trigger_o | output | 1 | One-cycle trigger pulse |
| cfar_thr_o | output | 16 | Detection threshold to the comparator |
| stream_mask_o | output | 3 | Per-stream output enable |
| long_chirp_o | output | 16 | Long chirp duration |
| short_chirp_o | output | 16 | Short chirp duration |
| long_listen_o | output | 16 | Listen window after long chirp |
| guard_o | output | 16 | Guard interval |
| short_listen_o | output | 16 | Listen window after short chirp |
| chirps_per_elev_o | output | 8 | Chirps per elevation step |
| stat_valid_o | output | 1 | Status word valid (clk_tx_i) |
| stat_data_o | output | 16 | Status word |
| stat_last_o | output | 1 | Marks the seventh status word |

## Verification
A decode fault shows up at the register ports in the first cycle after the command edge. That fault can be a wrong register hit, an unknown opcode that writes, or a trigger that lasts too long. The bench sweeps all 255 non-status opcodes and compares every register after each one. A fault in the snapshot or packer shows up in the status words within one burst: a swapped field, wrong packing, or a snapshot taken late. A fault in the toggle path shows up as a burst that never comes, comes twice, or comes late. These are caught by counting bursts per request and by measuring the delay in transmit cycles.

// File: rtl/host_cmd_pkg.sv
`timescale 1ns/1ps
package host_cmd_pkg;
  localparam int OP_W       = 8;
  localparam int NUM_TIM    = 5;
  localparam int STAT_WORDS = 7;

  localparam logic [OP_W-1:0] OP_MODE = 8'h01;
  localparam logic [OP_W-1:0] OP_TRIG = 8'h02;
  localparam logic [OP_W-1:0] OP_THR  = 8'h03;
  localparam logic [OP_W-1:0] OP_STRM = 8'h04;
  localparam logic [OP_W-1:0] OP_TIM0 = 8'h10;
  localparam logic [OP_W-1:0] OP_CPE  = 8'h15;
  localparam logic [OP_W-1:0] OP_STAT = 8'hFF;
endpackage

// File: rtl/cmd_regfile.sv
`timescale 1ns/1ps
module cmd_regfile
  import host_cmd_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int MODE_W = 2,
  parameter int STRM_W = 3,
  parameter int CPE_W  = 8,
  parameter logic [STRM_W-1:0] STRM_RST = 3'b001
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   cmd_valid_i,
  input  logic [OP_W-1:0]                        cmd_op_i,
  input  logic [VAL_W-1:0]                       cmd_val_i,
  output logic [MODE_W-1:0]                      mode_o,
  output logic                                   trig_o,
  output logic [VAL_W-1:0]                       thr_o,
  output logic [STRM_W-1:0]                      strm_o,
  output logic [NUM_TIM-1:0][VAL_W-1:0]          tim_o,
  output logic [CPE_W-1:0]                       cpe_o,
  output logic                                   stat_tgl_o,
  output logic [STAT_WORDS-1:0][VAL_W-1:0]       snap_o
);
  logic [MODE_W-1:0]                mode_q;
  logic                             trig_q;
  logic [VAL_W-1:0]                 thr_q;
  logic [STRM_W-1:0]                strm_q;
  logic [NUM_TIM-1:0][VAL_W-1:0]    tim_q;
  logic [CPE_W-1:0]                 cpe_q;
  logic                             tgl_q;
  logic [STAT_WORDS-1:0][VAL_W-1:0] snap_q;
  logic [STAT_WORDS-1:0][VAL_W-1:0] live_w;
  logic [NUM_TIM-1:0]               tim_we;
  logic                             op_known;

  always_comb begin
    op_known = (cmd_op_i == OP_MODE) || (cmd_op_i == OP_TRIG) ||
               (cmd_op_i == OP_THR)  || (cmd_op_i == OP_STRM) ||
               (cmd_op_i == OP_CPE)  || (cmd_op_i == OP_STAT) || (|tim_we);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      thr_q  <= '0;
      strm_q <= STRM_RST;
      cpe_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= cmd_valid_i && (cmd_op_i == OP_TRIG);
      if (cmd_valid_i) begin
        if (cmd_op_i == OP_MODE) mode_q <= cmd_val_i[MODE_W-1:0];
        if (cmd_op_i == OP_THR)  thr_q  <= cmd_val_i;
        if (cmd_op_i == OP_STRM) strm_q <= cmd_val_i[STRM_W-1:0];
        if (cmd_op_i == OP_CPE)  cpe_q  <= cmd_val_i[CPE_W-1:0];
      end
    end
  end

  // timing fields sit at consecutive opcodes from OP_TIM0
  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
    assign tim_we[g] = (cmd_op_i == OP_TIM0 + OP_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      tim_q[g] <= '0;
      else if (cmd_valid_i && tim_we[g]) tim_q[g] <= cmd_val_i;
    end
  end

  always_comb begin
    live_w[0] = '0;
    live_w[0][MODE_W-1:0]        = mode_q;
    live_w[0][MODE_W +: STRM_W]  = strm_q;
    live_w[0][VAL_W-1 -: CPE_W]  = cpe_q;
    live_w[1] = thr_q;
    for (int i = 0; i < NUM_TIM; i++) live_w[2+i] = tim_q[i];
  end

  // snapshot held until next request; transmit side reads it only after the toggle settles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      tgl_q  <= 1'b0;
    end else if (cmd_valid_i && (cmd_op_i == OP_STAT)) begin
      snap_q <= live_w;
      tgl_q  <= ~tgl_q;
    end
  end

  assign mode_o     = mode_q;
  assign trig_o     = trig_q;
  assign thr_o      = thr_q;
  assign strm_o     = strm_q;
  assign tim_o      = tim_q;
  assign cpe_o      = cpe_q;
  assign stat_tgl_o = tgl_q;
  assign snap_o     = snap_q;

  // R4
  trig_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> $past(cmd_valid_i && (cmd_op_i == OP_TRIG)));
  // R7
  unknown_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !op_known) |=> ($stable(mode_q) && $stable(thr_q) && $stable(strm_q)
                                     && $stable(tim_q) && $stable(cpe_q) && !trig_q));
  // R5
  thr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == OP_THR)) |=> (thr_q == $past(cmd_val_i)));
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> ($stable(mode_q) && $stable(thr_q) && $stable(tim_q) && $stable(tgl_q)));
endmodule

// File: rtl/toggle_sync.sv
`timescale 1ns/1ps
module toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tgl_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] ^ prev_q;

  // R12
  pulse_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (prev_q == $past(sync_q[STAGES-1])));
endmodule

// File: rtl/status_packer.sv
`timescale 1ns/1ps
module status_packer #(
  parameter int VAL_W = 16,
  parameter int WORDS = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [WORDS-1:0][VAL_W-1:0] snap_i,
  output logic                        valid_o,
  output logic [VAL_W-1:0]            data_o,
  output logic                        last_o
);
  localparam int IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic                        busy_q;
  logic                        pend_q;
  logic [IDX_W-1:0]            idx_q;
  logic [WORDS-1:0][VAL_W-1:0] shad_q;
  logic                        load;
  logic                        at_last;

  assign at_last = busy_q && (idx_q == LAST_IDX);
  assign load    = !busy_q && (start_i || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      idx_q  <= '0;
      shad_q <= '0;
    end else begin
      if (load) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        shad_q <= snap_i;
        pend_q <= 1'b0;
      end else begin
        if (start_i) pend_q <= 1'b1;
        if (at_last)     busy_q <= 1'b0;
        else if (busy_q) idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign valid_o = busy_q;
  assign data_o  = shad_q[idx_q];
  assign last_o  = at_last;

  // R8
  burst_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o);
  // R8
  burst_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o);
  // R9
  burst_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (idx_q == '0));
endmodule

// File: rtl/host_cmd_decoder.sv
`timescale 1ns/1ps
module host_cmd_decoder
  import host_cmd_pkg::*;
#(
  parameter int VAL_W    = 16,
  parameter int MODE_W   = 2,
  parameter int STRM_W   = 3,
  parameter int CPE_W    = 8,
  parameter int SYNC_STG = 2,
  localparam int CMD_W   = OP_W + VAL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_tx_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              trigger_o,
  output logic [VAL_W-1:0]  cfar_thr_o,
  output logic [STRM_W-1:0] stream_mask_o,
  output logic [VAL_W-1:0]  long_chirp_o,
  output logic [VAL_W-1:0]  short_chirp_o,
  output logic [VAL_W-1:0]  long_listen_o,
  output logic [VAL_W-1:0]  guard_o,
  output logic [VAL_W-1:0]  short_listen_o,
  output logic [CPE_W-1:0]  chirps_per_elev_o,
  output logic              stat_valid_o,
  output logic [VAL_W-1:0]  stat_data_o,
  output logic              stat_last_o
);
  logic [NUM_TIM-1:0][VAL_W-1:0]    tim;
  logic [STAT_WORDS-1:0][VAL_W-1:0] snap;
  logic                             tgl;
  logic                             req_pulse;

  cmd_regfile #(
    .VAL_W(VAL_W), .MODE_W(MODE_W), .STRM_W(STRM_W), .CPE_W(CPE_W),
    .STRM_RST(STRM_W'(1))
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_word_i[CMD_W-1 -: OP_W]),
    .cmd_val_i  (cmd_word_i[VAL_W-1:0]),
    .mode_o     (mode_o),
    .trig_o     (trigger_o),
    .thr_o      (cfar_thr_o),
    .strm_o     (stream_mask_o),
    .tim_o      (tim),
    .cpe_o      (chirps_per_elev_o),
    .stat_tgl_o (tgl),
    .snap_o     (snap)
  );

  assign long_chirp_o   = tim[0];
  assign short_chirp_o  = tim[1];
  assign long_listen_o  = tim[2];
  assign guard_o        = tim[3];
  assign short_listen_o = tim[4];

  toggle_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_tx_i),
    .rst_ni (rst_ni),
    .tgl_i  (tgl),
    .pulse_o(req_pulse)
  );

  status_packer #(.VAL_W(VAL_W), .WORDS(STAT_WORDS)) u_pack (
    .clk_i  (clk_tx_i),
    .rst_ni (rst_ni),
    .start_i(req_pulse),
    .snap_i (snap),
    .valid_o(stat_valid_o),
    .data_o (stat_data_o),
    .last_o (stat_last_o)
  );
endmodule

// File: tb/host_cmd_decoder_bench.sv
`timescale 1ns/1ps
module host_cmd_decoder_bench;
  logic        clk = 0, clk_tx = 0, rst_n = 0;
  logic        cmd_valid = 0;
  logic [23:0] cmd_word = '0;
  logic [1:0]  mode;
  logic        trig;
  logic [15:0] thr, lch, sch, lls, grd, sls, sd;
  logic [2:0]  strm;
  logic [7:0]  cpe;
  logic        sv, sl;

  int n_run = 0, n_fail = 0;
  int tx_cyc = 0, widx = 0, pcnt = 0, nreq = 0;
  logic [15:0] exp_w [0:7][0:6];
  int          req_cyc [0:7];
  int          first_cyc [0:7];
  bit          lat_chk [0:7];

  // bench model
  logic [1:0]  m_mode;
  logic [15:0] m_thr;
  logic [2:0]  m_strm;
  logic [15:0] m_tim [0:4];
  logic [7:0]  m_cpe;

  always #4 clk = ~clk;
  always #7 clk_tx = ~clk_tx;

  host_cmd_decoder u_host_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .clk_tx_i(clk_tx),
    .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .mode_o(mode), .trigger_o(trig), .cfar_thr_o(thr), .stream_mask_o(strm),
    .long_chirp_o(lch), .short_chirp_o(sch), .long_listen_o(lls), .guard_o(grd),
    .short_listen_o(sls), .chirps_per_elev_o(cpe),
    .stat_valid_o(sv), .stat_data_o(sd), .stat_last_o(sl)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(mode == m_mode, req, 32'(mode), 32'(m_mode));
    chk(thr  == m_thr,  req, 32'(thr),  32'(m_thr));
    chk(strm == m_strm, req, 32'(strm), 32'(m_strm));
    chk(lch  == m_tim[0], req, 32'(lch), 32'(m_tim[0]));
    chk(sch  == m_tim[1], req, 32'(sch), 32'(m_tim[1]));
    chk(lls  == m_tim[2], req, 32'(lls), 32'(m_tim[2]));
    chk(grd  == m_tim[3], req, 32'(grd), 32'(m_tim[3]));
    chk(sls  == m_tim[4], req, 32'(sls), 32'(m_tim[4]));
    chk(cpe  == m_cpe,  req, 32'(cpe),  32'(m_cpe));
  endtask

  task automatic model_apply(input logic [7:0] op, input logic [15:0] v);
    case (op)
      8'h01: m_mode = v[1:0];
      8'h03: m_thr  = v;
      8'h04: m_strm = v[2:0];
      8'h10, 8'h11, 8'h12, 8'h13, 8'h14: m_tim[op - 8'h10] = v;
      8'h15: m_cpe  = v[7:0];
      default: ;
    endcase
  endtask

  task automatic send(input logic [7:0] op, input logic [15:0] v);
    @(negedge clk);
    cmd_valid = 1; cmd_word = {op, v};
    @(negedge clk);
    cmd_valid = 0; cmd_word = '0;
    model_apply(op, v);
  endtask

  task automatic request(input bit lat);
    exp_w[nreq][0] = {m_cpe, 3'b000, m_strm, m_mode};
    exp_w[nreq][1] = m_thr;
    for (int i = 0; i < 5; i++) exp_w[nreq][2+i] = m_tim[i];
    lat_chk[nreq] = lat;
    send(8'hFF, 16'h0);
    req_cyc[nreq] = tx_cyc;
    nreq++;
  endtask

  task automatic wait_bursts(input int n);
    for (int i = 0; i < 100 && pcnt < n; i++) @(negedge clk_tx);
    chk(pcnt == n, "R8 burst count", 32'(pcnt), 32'(n));
  endtask

  // transmit monitor, samples away from the edge
  always @(negedge clk_tx) begin
    tx_cyc++;
    if (rst_n && sv) begin
      if (pcnt >= nreq) begin
        chk(0, "R8 unrequested burst", 32'(pcnt), 32'(nreq));
      end else begin
        if (widx == 0) first_cyc[pcnt] = tx_cyc;
        chk(sd == exp_w[pcnt][widx], "R9 status word", 32'(sd), 32'(exp_w[pcnt][widx]));
        chk(sl == (widx == 6), "R8 last flag", 32'(sl), 32'(widx == 6));
        if (widx == 6) begin
          if (lat_chk[pcnt])
            chk(first_cyc[pcnt] - req_cyc[pcnt] <= 5, "R11 latency",
                32'(first_cyc[pcnt] - req_cyc[pcnt]), 32'd5);
          widx = 0;
          pcnt++;
        end else widx++;
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_fail++; n_run++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    m_mode = 0; m_thr = 0; m_strm = 3'b001; m_cpe = 0;
    for (int i = 0; i < 5; i++) m_tim[i] = 0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk_regs("R1 in reset");
    chk(!trig && !sv, "R1 outputs low", {30'b0, trig, sv}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk_regs("R1 after release");

    // R2 idle word ignored
    @(negedge clk); cmd_word = {8'h03, 16'hBEEF};
    @(negedge clk); cmd_word = '0;
    chk_regs("R2 valid low");

    // sweep of every non-status opcode; the model picks the expected register
    for (int op = 0; op < 255; op++) begin
      v = {8'(op) ^ 8'hA5, ~8'(op)};
      send(8'(op), v);
      chk(trig == (op == 2), "R4 trigger pulse", 32'(trig), 32'(op == 2));
      if (op == 1)                 chk_regs("R3 mode");
      else if (op == 2)            chk_regs("R4 no store");
      else if (op == 3 || op == 4) chk_regs("R5 thr/mask");
      else if (op >= 16 && op <= 21) chk_regs("R6 timing");
      else                         chk_regs("R7 unknown op");
      @(negedge clk);
      chk(!trig, "R4 single cycle", 32'(trig), 0);
    end

    // R3 all mode values
    for (int m = 0; m < 4; m++) begin
      send(8'h01, 16'(m) | 16'hFFFC);
      chk(mode == 2'(m), "R3 mode value", 32'(mode), 32'(m));
    end

    // R9 R11 basic burst
    send(8'h03, 16'h1357); send(8'h04, 16'h0006); send(8'h15, 16'hABCD);
    send(8'h10, 16'h1111); send(8'h14, 16'hFEDC); send(8'h01, 16'h0002);
    request(1);
    wait_bursts(1);

    // R10 writes after the request do not enter the burst
    request(1);
    send(8'h03, 16'h2468); send(8'h01, 16'h0001); send(8'h12, 16'h0F0F);
    wait_bursts(2);

    // R12 request during an active burst
    request(1);
    for (int i = 0; i < 40 && !sv; i++) @(negedge clk_tx);
    send(8'h13, 16'h7777); send(8'h04, 16'h0003);
    request(0);
    wait_bursts(4);

    // R8 no extra bursts afterwards
    repeat (30) @(negedge clk_tx);
    chk(pcnt == nreq, "R8 one burst per request", 32'(pcnt), 32'(nreq));
    chk(!sv, "R8 idle after bursts", 32'(sv), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule